// File: doc/BRIEF.md
# Level-Sensitive Interrupt Pending Controller

This block is the front end of an interrupt controller for up to 96 interrupt lines, organised as three 32-bit words. Line n belongs to word n/32 at bit position n mod 32. Each clock edge samples the lines into an IRQ pending bank. That bank is a read-only view of the input levels, so a bit clears as soon as its line drops. A separate FIQ pending bank latches each rising level and holds it until software writes a one to that bit.

Software reaches the block through a single-cycle register port: byte address, write enable, write data and combinational read data. Through this port it reads both pending banks, reads and writes a per-line enable mask, and reads and writes a full-width NMI control word. The processor interrupt request is the OR of every IRQ pending bit whose enable bit is set. It is formed combinationally from the registered state, so it follows every input change and every register write.

Top module: `pic_level_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, every register reads zero and `irqOut` is low. Register writes made during reset have no effect.
- R2: The IRQ pending word k sits at byte address 0x10+4k, for k = 0..2. It reads the levels of lines 32k..32k+31 as they were sampled at the most recent clock edge. Line n appears at bit n mod 32.
- R3: Writes to the IRQ pending addresses are accepted and change no state. Both pending banks, the enable mask, the NMI word and `irqOut` are unaffected.
- R4: The FIQ pending word k sits at byte address 0x20+4k. A bit is set at a clock edge where its line is high and was low at the previous edge. The bit stays set after the line falls.
- R5: A write to a FIQ pending word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: When a FIQ bit is cleared by a write and set by a rising line at the same edge, the bit ends up set.
- R7: The enable word k sits at byte address 0x40+4k. It is read/write and stores the full 32-bit written value.
- R8: The NMI control word sits at byte address 0x00. It is read/write and stores the full 32-bit written value.
- R9: `irqOut` is high exactly when some IRQ pending bit and the enable bit at the same position are both 1.
- R10: Every other address reads zero, and writes to it change nothing. This includes addresses whose two low bits are not zero, and word index 3 of any bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | 96 | Level-sensitive interrupt lines; line n is bit n |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Write strobe for the current cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational from registered state |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
A change on `irqLines` becomes visible one clock edge later, both in the IRQ and FIQ pending reads and on `irqOut`. A register write shows up in the read data and in `irqOut` right after the edge that takes it in. A read needs no edge: the data for an address is valid in the cycle that address is driven. The bench drives each new input set at the falling edge and compares the outputs a little later in that same low phase, against a reference model that advances once at every rising edge. Every result is therefore compared in the cycle it is due, never earlier or later.

// File: rtl/pic_pkg.sv
package pic_pkg;

  // Word index field is two bits wide: up to four words per bank.
  localparam int IDX_W     = 2;
  localparam int MAX_WORDS = 1 << IDX_W;

  // Address region codes held in address bits [7:4].
  localparam logic [3:0] REGION_NMI = 4'h0;
  localparam logic [3:0] REGION_IRQ = 4'h1;
  localparam logic [3:0] REGION_FIQ = 4'h2;
  localparam logic [3:0] REGION_EN  = 4'h4;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_IRQ  = 3'd1,
    RD_FIQ  = 3'd2,
    RD_EN   = 3'd3,
    RD_NMI  = 3'd4
  } rdSel_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic             fiqClr;
    logic             enWr;
    logic             nmiWr;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] wordIdx;
  } ctrlStrobe_t;

endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrlStrobe_t       strobe
);

  logic             upperZero;
  logic [3:0]       region;
  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             idxInRange;

  generate
    if (ADDR_W > 8) begin : g_wide
      assign upperZero = (regAddr[ADDR_W-1:8] == '0);
    end else begin : g_narrow
      assign upperZero = 1'b1;
    end
  endgenerate

  assign region     = regAddr[7:4];
  assign wordIdx    = regAddr[3:2];
  assign aligned    = (regAddr[1:0] == 2'b00);
  assign idxInRange = ({1'b0, wordIdx} < (IDX_W+1)'(NUM_WORDS));

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = RD_NONE;
    strobe.wordIdx = wordIdx;
    if (upperZero && aligned) begin
      unique case (region)
        REGION_NMI: begin
          if (wordIdx == '0) begin
            strobe.rdSel = RD_NMI;
            strobe.nmiWr = regWrEn;
          end
        end
        REGION_IRQ: begin
          // Read-only view; a write here is accepted and dropped.
          if (idxInRange) strobe.rdSel = RD_IRQ;
        end
        REGION_FIQ: begin
          if (idxInRange) begin
            strobe.rdSel  = RD_FIQ;
            strobe.fiqClr = regWrEn;
          end
        end
        REGION_EN: begin
          if (idxInRange) begin
            strobe.rdSel = RD_EN;
            strobe.enWr  = regWrEn;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_WORDS*WORD_W-1:0] irqLines,
  input  logic [WORD_W-1:0]           wrData,
  input  ctrlStrobe_t                 strobe,
  output logic [WORD_W-1:0]           rdData,
  output logic                        irqOut
);

  logic [NUM_WORDS-1:0][WORD_W-1:0] irqView;
  logic [NUM_WORDS-1:0][WORD_W-1:0] fiqView;
  logic [NUM_WORDS-1:0][WORD_W-1:0] enView;
  logic [NUM_WORDS-1:0]             wordActive;
  logic [WORD_W-1:0]                nmiQ;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] irqPendQ;
    logic [WORD_W-1:0] fiqPendQ;
    logic [WORD_W-1:0] enableQ;
    logic [WORD_W-1:0] lineWord;
    logic [WORD_W-1:0] riseWord;
    logic [WORD_W-1:0] clrWord;
    logic              hit;

    assign lineWord = irqLines[w*WORD_W +: WORD_W];
    assign hit      = (strobe.wordIdx == IDX_W'(w));
    // Rising level: high now, low at the previous sample.
    assign riseWord = lineWord & ~irqPendQ;
    assign clrWord  = (strobe.fiqClr && hit) ? wrData : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        irqPendQ <= '0;
        fiqPendQ <= '0;
        enableQ  <= '0;
      end else begin
        irqPendQ <= lineWord;
        // Set is applied after clear, so a same-edge set wins.
        fiqPendQ <= (fiqPendQ & ~clrWord) | riseWord;
        if (strobe.enWr && hit) enableQ <= wrData;
      end
    end

    assign irqView[w]    = irqPendQ;
    assign fiqView[w]    = fiqPendQ;
    assign enView[w]     = enableQ;
    assign wordActive[w] = |(irqPendQ & enableQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             nmiQ <= '0;
    else if (strobe.nmiWr) nmiQ <= wrData;
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdSel == RD_NMI) begin
      rdData = nmiQ;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (strobe.wordIdx == IDX_W'(w)) begin
          unique case (strobe.rdSel)
            RD_IRQ:  rdData = irqView[w];
            RD_FIQ:  rdData = fiqView[w];
            RD_EN:   rdData = enView[w];
            default: ;
          endcase
        end
      end
    end
  end

  assign irqOut = |wordActive;

endmodule

// File: rtl/pic_level_ctrl.sv
module pic_level_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_WORDS*WORD_W-1:0] irqLines,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWrEn,
  input  logic [WORD_W-1:0]           regWrData,
  output logic [WORD_W-1:0]           regRdData,
  output logic                        irqOut
);

  ctrlStrobe_t strobe;

  pic_ctrl #(
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  pic_datapath #(
    .NUM_WORDS(NUM_WORDS),
    .WORD_W   (WORD_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqLines(irqLines),
    .wrData  (regWrData),
    .strobe  (strobe),
    .rdData  (regRdData),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/pic_level_ctrl_sva.sv
module pic_level_ctrl_sva #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] lineWord0,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [WORD_W-1:0] regWrData,
  input logic [WORD_W-1:0] regRdData,
  input logic              irqOut
);

  localparam logic [ADDR_W-1:0] A_NMI  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_IRQ0 = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_FIQ0 = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_EN0  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_GAP  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_ODD  = ADDR_W'(8'h11);

  logic              pastValid;
  logic [WORD_W-1:0] linesPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastValid <= 1'b0;
      linesPrev <= '0;
    end else begin
      pastValid <= 1'b1;
      linesPrev <= lineWord0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !pastValid |-> (!irqOut && regRdData == '0)); // R1

  AST_IRQ_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_IRQ0) |-> (regRdData == linesPrev)); // R2

  AST_FIQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_FIQ0 && $past(regAddr == A_FIQ0 && !regWrEn))
      |-> ((regRdData & $past(regRdData)) == $past(regRdData))); // R4

  AST_FIQ_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_FIQ0 && regWrData == '1)
      |=> (regAddr != A_FIQ0
           || regRdData == $past(lineWord0 & ~linesPrev))); // R5

  AST_EN_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_EN0)
      |=> (regAddr != A_EN0 || regRdData == $past(regWrData))); // R7

  AST_NMI_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == A_NMI)
      |=> (regAddr != A_NMI || regRdData == $past(regWrData))); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == A_GAP || regAddr == A_ODD) |-> (regRdData == '0)); // R10

endmodule

bind pic_level_ctrl pic_level_ctrl_sva #(
  .WORD_W(WORD_W),
  .ADDR_W(ADDR_W)
) u_sva (
  .clk      (clk),
  .rstN     (rstN),
  .lineWord0(irqLines[WORD_W-1:0]),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .irqOut   (irqOut)
);

// File: tb/pic_level_ctrl_bench.sv
`timescale 1ns/1ps
module pic_level_ctrl_bench;

  localparam int NW = 3;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NW*WW-1:0] lines = '0;
  logic [7:0]    addr = 8'h00;
  logic          wrEn = 1'b0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdData;
  logic          irqOut;

  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 1'b0;
  string curTag = "R1";

  // Reference model state
  logic [WW-1:0] mIrq [NW];
  logic [WW-1:0] mFiq [NW];
  logic [WW-1:0] mEn  [NW];
  logic [WW-1:0] mNmi;

  always #10 clk = ~clk; // 50 MHz

  pic_level_ctrl u_pic_level_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .irqLines (lines),
    .regAddr  (addr),
    .regWrEn  (wrEn),
    .regWrData(wdata),
    .regRdData(rdData),
    .irqOut   (irqOut)
  );

  initial begin
    for (int k = 0; k < NW; k++) begin
      mIrq[k] = '0; mFiq[k] = '0; mEn[k] = '0;
    end
    mNmi = '0;
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NW; k++) begin
        mIrq[k] = '0; mFiq[k] = '0; mEn[k] = '0;
      end
      mNmi = '0;
    end else begin
      for (int k = 0; k < NW; k++) begin
        logic [WW-1:0] now;
        logic [WW-1:0] clr;
        now = lines[k*WW +: WW];
        clr = (wrEn && addr == 8'(8'h20 + 4*k)) ? wdata : '0;
        mFiq[k] = (mFiq[k] & ~clr) | (now & ~mIrq[k]);
        mIrq[k] = now;
        if (wrEn && addr == 8'(8'h40 + 4*k)) mEn[k] = wdata;
      end
      if (wrEn && addr == 8'h00) mNmi = wdata;
    end
  end

  function automatic logic [WW-1:0] modelRead(input logic [7:0] a);
    logic [WW-1:0] r;
    r = '0;
    if (a == 8'h00) r = mNmi;
    for (int k = 0; k < NW; k++) begin
      if (a == 8'(8'h10 + 4*k)) r = mIrq[k];
      if (a == 8'(8'h20 + 4*k)) r = mFiq[k];
      if (a == 8'(8'h40 + 4*k)) r = mEn[k];
    end
    return r;
  endfunction

  function automatic logic modelIrq();
    logic any;
    any = 1'b0;
    for (int k = 0; k < NW; k++) any |= |(mIrq[k] & mEn[k]);
    return any;
  endfunction

  task automatic compareNow();
    logic [WW-1:0] expRd;
    logic          expIrq;
    expRd  = modelRead(addr);
    expIrq = modelIrq();
    vectors++;
    if (rdData !== expRd) begin
      miscompares++;
      $display("FAIL %s addr=%02h rdData=%08h expected=%08h", curTag, addr, rdData, expRd);
    end
    vectors++;
    if (irqOut !== expIrq) begin
      miscompares++;
      $display("FAIL R9 (%s) irqOut=%0b expected=%0b", curTag, irqOut, expIrq);
    end
  endtask

  task automatic step(input logic [NW*WW-1:0] l, input logic [7:0] a,
                      input logic we, input logic [WW-1:0] d, input string tag);
    @(negedge clk);
    lines = l; addr = a; wrEn = we; wdata = d; curTag = tag;
    #3;
    compareNow();
  endtask

  task automatic readAll(input logic [NW*WW-1:0] l, input string tag);
    logic [7:0] list [10] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28, 8'h40, 8'h44, 8'h48};
    foreach (list[i]) step(l, list[i], 1'b0, '0, tag);
  endtask

  logic [NW*WW-1:0] pat;

  initial begin
    // R1: reset state; writes during reset are dropped
    step('1, 8'h00, 1'b1, 32'hFFFF_FFFF, "R1");
    step('1, 8'h40, 1'b1, 32'hFFFF_FFFF, "R1");
    readAll('1, "R1");
    @(negedge clk);
    rstN = 1'b1;
    readAll('0, "R1");

    // R2: live view of line levels, bit n -> word n/32 bit n%32
    pat = '0; pat[0] = 1'b1; pat[31] = 1'b1; pat[32] = 1'b1; pat[95] = 1'b1;
    step(pat, 8'h10, 1'b0, '0, "R2");
    readAll(pat, "R2");
    pat = {32'hA5A5_0F0F, 32'h1234_5678, 32'h8000_0001};
    readAll(pat, "R2");
    readAll('0, "R2");

    // R4: rising level latches and holds after the line falls
    pat = {32'h0000_0100, 32'h0001_0000, 32'h8000_0002};
    step(pat, 8'h20, 1'b0, '0, "R4");
    step('0, 8'h20, 1'b0, '0, "R4");
    readAll('0, "R4");

    // R3: writes to IRQ pending are dropped
    step('0, 8'h10, 1'b1, 32'hFFFF_FFFF, "R3");
    step('0, 8'h14, 1'b1, 32'hFFFF_FFFF, "R3");
    step('0, 8'h18, 1'b1, 32'hFFFF_FFFF, "R3");
    readAll('0, "R3");

    // R5: write-one-to-clear, zeros leave bits
    step('0, 8'h20, 1'b1, 32'h0000_0002, "R5");
    step('0, 8'h20, 1'b0, '0, "R5");
    step('0, 8'h24, 1'b1, 32'hFFFE_FFFF, "R5");
    step('0, 8'h24, 1'b0, '0, "R5");
    step('0, 8'h28, 1'b1, 32'hFFFF_FFFF, "R5");
    readAll('0, "R5");

    // R6: set and clear at the same edge, set wins
    step('0, 8'h20, 1'b1, 32'hFFFF_FFFF, "R6");
    pat = '0; pat[31] = 1'b1; pat[3] = 1'b1;
    step(pat, 8'h20, 1'b1, 32'hFFFF_FFFF, "R6");
    step(pat, 8'h20, 1'b0, '0, "R6");
    step('0, 8'h20, 1'b0, '0, "R6");

    // R7 / R9: enable mask and the request output
    step('0, 8'h44, 1'b1, 32'h0000_0400, "R7");
    step('0, 8'h44, 1'b0, '0, "R7");
    pat = '0; pat[32+10] = 1'b1;
    step(pat, 8'h44, 1'b0, '0, "R9");
    step(pat, 8'h14, 1'b0, '0, "R9");
    pat = '0; pat[32+11] = 1'b1;
    step(pat, 8'h14, 1'b0, '0, "R9");
    step(pat, 8'h48, 1'b1, 32'hFFFF_FFFF, "R9");
    step(pat, 8'h48, 1'b0, '0, "R9");
    step(pat, 8'h44, 1'b1, 32'h0000_0800, "R9");
    step(pat, 8'h44, 1'b0, '0, "R9");
    step('0, 8'h44, 1'b0, '0, "R9");

    // R8: NMI word stores full width
    step('0, 8'h00, 1'b1, 32'hDEAD_BEEF, "R8");
    step('0, 8'h00, 1'b0, '0, "R8");
    step('0, 8'h00, 1'b1, 32'h0000_0001, "R8");
    step('0, 8'h00, 1'b0, '0, "R8");

    // R10: unmapped, misaligned and out-of-range addresses
    begin
      logic [7:0] bad [8] = '{8'h04, 8'h08, 8'h1C, 8'h2C, 8'h4C, 8'h11, 8'h42, 8'h80};
      foreach (bad[i]) step('1, bad[i], 1'b1, 32'hFFFF_FFFF, "R10");
      foreach (bad[i]) step('1, bad[i], 1'b0, '0, "R10");
      readAll('1, "R10");
    end

    // Mixed traffic across all functions
    begin
      logic [7:0] pool [16] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24, 8'h28,
                                 8'h40, 8'h44, 8'h48, 8'h04, 8'h1C, 8'h21, 8'h4C,
                                 8'h60, 8'h20};
      for (int n = 0; n < 3000; n++) begin
        logic [NW*WW-1:0] l;
        l = {$urandom, $urandom, $urandom};
        if (n % 3 == 0) l = l & {$urandom, $urandom, $urandom};
        step(l, pool[$urandom % 16], ($urandom % 3) == 0, $urandom, "mix");
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired: vectors=%0d expected completion", vectors);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule